// File: doc/BRIEF.md
# Serial Byte Transmitter with Pin Override for Break

This block serializes bytes taken from a transmit queue onto a single serial line. Each byte goes out as an asynchronous frame: a low start bit, the data bits least significant first, an optional parity bit, and one high stop bit. Every bit is held for one interval of an externally supplied baud tick. The block asks the queue for a byte only at the moment it begins a frame, so bytes that have not started stay in the queue.

A transmit enable input gates the transmitter. Dropping it resets the shifter at once, even part way through a frame: the partly sent byte is dropped and the serial output returns high. A two-bit pin mode field, together with a pin data bit, decides what reaches the line pin. In serial mode the pin carries the shifter output. In drive mode the pin carries the pin data bit, which lets software hold the line low to send a break. In the two remaining modes the pin is released.

To send a break, software sets the pin data bit low, then selects drive mode, then clears the enable. The line stays low for as long as software wants.

Top module: `uart_tx_brk`

## Requirements
- R1: During and straight after reset, txd is 1, txd_oe is 1, fifo_pop is 0 and no frame is in progress.
- R2: A frame is a start bit of 0, then 8 data bits with bit 0 first, then a stop bit of 1. Each bit is held from one baud tick to the next. fifo_pop is high for exactly the clock that has the baud tick which starts the frame, and that clock loads fifo_data.
- R3: With par_en=1, a parity bit follows the last data bit. With par_odd=0 it makes the number of ones in data plus parity even. With par_odd=1 it makes that number odd.
- R4: A frame starts only on a baud tick with tx_en=1 and fifo_empty=0. When the queue is not empty at the tick that ends a stop bit, the next start bit follows with no idle bit in between.
- R5: With no frame in progress, the serial output is 1.
- R6: With tx_en=0, the serial output is 1 from the next clock on, the frame in progress is discarded and no pop occurs. Queue entries not yet popped are kept, and after re-enabling they are sent in order.
- R7: With pin_mode=2'b10, txd equals pin_dat and txd_oe is 1. This holds whatever the state of the transmitter, so pin_dat=0 forms a break.
- R8: With pin_mode=2'b01 or 2'b11, txd_oe is 0 and txd reads 1.
- R9: With pin_mode=2'b00, txd_oe is 1 and txd follows the serial output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-clock pulse marking each bit boundary |
| tx_en | input | 1 | Transmit enable; low aborts and holds the transmitter idle |
| par_en | input | 1 | Add a parity bit to each frame |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| fifo_empty | input | 1 | Transmit queue has no entry |
| fifo_data | input | 8 | Head entry of the queue (shown ahead of the pop) |
| fifo_pop | output | 1 | Takes the head entry this clock |
| pin_dat | input | 1 | Level driven in pin drive mode |
| pin_mode | input | 2 | 00 serial, 10 drive pin_dat, 01/11 released |
| txd | output | 1 | Line pin level |
| txd_oe | output | 1 | Line pin output enable |

## Verification
A bit-level monitor rebuilds every frame seen on the line and compares it with a scoreboard of bytes queued by the driver. Data values with alternating, all-zero, all-one and single-bit patterns are sent back to back without parity and then with even and odd parity. This separates mistakes in bit order, in parity sense and in stop-bit or gap timing. A mid-frame drop of the enable shows whether the shifter aborts at once while the queued byte survives and goes out after re-enable. The break sequence and the released pin modes are checked at the pin while a frame is being shifted underneath.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [1:0] {
    PM_SERIAL = 2'b00,
    PM_REL_A  = 2'b01,
    PM_DRIVE  = 2'b10,
    PM_REL_B  = 2'b11
  } pin_mode_e;

  // Pin is driven in the serial and drive modes only.
  function automatic logic mode_drives(input pin_mode_e m);
    return (m == PM_SERIAL) || (m == PM_DRIVE);
  endfunction

endpackage

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_en,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic              ser_out
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  // Frame image, LSB leaves first: start, data, parity or stop, stop.
  function automatic logic [FRAME_W-1:0] frame_image(input logic [DATA_W-1:0] d,
                                                     input logic pe, input logic po);
    logic [FRAME_W-1:0] f;
    f = '1;
    f[0] = 1'b0;
    f[DATA_W:1] = d;
    if (pe) f[DATA_W+1] = (^d) ^ po;
    return f;
  endfunction

  function automatic logic [CNT_W-1:0] frame_len(input logic pe);
    return pe ? CNT_W'(DATA_W + 3) : CNT_W'(DATA_W + 2);
  endfunction

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   left;
  logic               busy;
  logic               last_bit;
  logic               start;

  assign busy     = (left != '0);
  assign last_bit = busy && baud_tick && (left == CNT_W'(1));
  assign start    = tx_en && baud_tick && !fifo_empty && (!busy || last_bit);
  assign fifo_pop = start;
  assign ser_out  = shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      left  <= '0;
    end else if (!tx_en) begin
      shreg <= '1;
      left  <= '0;
    end else if (start) begin
      shreg <= frame_image(fifo_data, par_en, par_odd);
      left  <= frame_len(par_en);
    end else if (busy && baud_tick) begin
      shreg <= {1'b1, shreg[FRAME_W-1:1]};
      left  <= left - CNT_W'(1);
    end
  end

  // R4: pop only on an enabled tick with data available
  a_r4_pop_gated: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (tx_en && baud_tick && !fifo_empty));

  // R2: the clock after a pop shows the start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> !ser_out);

  // R2: a bit is held between ticks
  a_r2_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !baud_tick) |=> $stable(ser_out));

  // R6: disable aborts immediately
  a_r6_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (ser_out && !busy));

  // R5: idle line is high
  a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ser_out);

endmodule

// File: rtl/uart_tx_pin.sv
module uart_tx_pin
  import uart_tx_pkg::*;
(
  input  logic       ser_out,
  input  logic       pin_dat,
  input  logic [1:0] pin_mode,
  output logic       txd,
  output logic       txd_oe
);
  pin_mode_e mode;
  assign mode = pin_mode_e'(pin_mode);

  always_comb begin
    txd_oe = mode_drives(mode);
    case (mode)
      PM_SERIAL: txd = ser_out;
      PM_DRIVE:  txd = pin_dat;
      default:   txd = 1'b1;   // released pin reads high
    endcase
  end
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_en,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              fifo_pop,
  input  logic              pin_dat,
  input  logic [1:0]        pin_mode,
  output logic              txd,
  output logic              txd_oe
);
  logic ser_out;

  uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
    .par_en(par_en), .par_odd(par_odd), .fifo_empty(fifo_empty),
    .fifo_data(fifo_data), .fifo_pop(fifo_pop), .ser_out(ser_out)
  );

  uart_tx_pin u_pin (
    .ser_out(ser_out), .pin_dat(pin_dat), .pin_mode(pin_mode),
    .txd(txd), .txd_oe(txd_oe)
  );

  // R7: drive mode with low data forms a break
  a_r7_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_mode == 2'b10 && !pin_dat) |-> (!txd && txd_oe));

  // R8: released modes do not drive and read high
  a_r8_released: assert property (@(posedge clk) disable iff (!rst_n)
    pin_mode[0] |-> (!txd_oe && txd));

  // R9: serial mode drives the line, idle high after abort
  a_r9_serial_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_mode == 2'b00 && !tx_en) |=> (pin_mode != 2'b00 || (txd && txd_oe)));

endmodule

// File: tb/sim_uart_tx_brk.sv
`timescale 1ns/100ps
module sim_uart_tx_brk;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic tx_en = 1'b0;
  logic par_en = 1'b0;
  logic par_odd = 1'b0;
  logic fifo_empty;
  logic [7:0] fifo_data;
  logic fifo_pop;
  logic pin_dat = 1'b1;
  logic [1:0] pin_mode = 2'b00;
  logic txd, txd_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_tx_brk u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
    .par_en(par_en), .par_odd(par_odd), .fifo_empty(fifo_empty),
    .fifo_data(fifo_data), .fifo_pop(fifo_pop), .pin_dat(pin_dat),
    .pin_mode(pin_mode), .txd(txd), .txd_oe(txd_oe)
  );

  // transmit queue model, head shown ahead of the pop
  logic [7:0] fq[$];
  logic [7:0] eq[$];
  always_comb begin
    fifo_empty = (fq.size() == 0);
    fifo_data  = fifo_empty ? 8'h00 : fq[0];
  end
  always @(posedge clk) if (fifo_pop && fq.size() > 0) void'(fq.pop_front());

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // baud tick: one clock in four
  initial begin
    forever begin
      repeat (3) @(negedge clk) baud_tick = 1'b0;
      @(negedge clk) baud_tick = 1'b1;
    end
  end

  logic tick_q = 1'b0;
  always @(posedge clk) tick_q <= baud_tick;

  // monitor: one sample per bit, just after the tick edge (R2, R3, R4, R9)
  bit mon_on = 0;
  int mstate = 0;
  int nb = 0;
  logic [7:0] acc;
  logic pbit;
  always @(negedge clk) begin
    if (!mon_on) mstate = 0;
    else if (tick_q) begin
      case (mstate)
        0: if (txd == 1'b0) begin mstate = 1; nb = 0; acc = '0; end
        1: begin
          acc[nb] = txd;
          nb++;
          if (nb == 8) mstate = par_en ? 2 : 3;
        end
        2: begin pbit = txd; mstate = 3; end
        default: begin
          if (eq.size() == 0) check(0, "R4 unexpected frame", acc, 0);
          else begin
            logic [7:0] e;
            e = eq.pop_front();
            check(acc == e, "R2 data", acc, e);
            if (par_en)
              check(((($countones(acc) + pbit) % 2) == (par_odd ? 1 : 0)),
                    "R3 parity", pbit, par_odd);
          end
          check(txd == 1'b1, "R2 stop bit", txd, 1);
          mstate = 0;
        end
      endcase
    end
  end

  task automatic send(input logic [7:0] b);
    fq.push_back(b);
    eq.push_back(b);
  endtask

  task automatic drain();
    while (eq.size() != 0 || mstate != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  int pops = 0;
  always @(posedge clk) if (fifo_pop) pops++;

  initial begin
    repeat (3) @(negedge clk);
    check(txd == 1'b1, "R1 txd in reset", txd, 1);
    check(txd_oe == 1'b1, "R1 oe in reset", txd_oe, 1);
    check(fifo_pop == 1'b0, "R1 pop in reset", fifo_pop, 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check(txd == 1'b1, "R1 idle after reset", txd, 1);

    // back to back without parity (R2, R4, R9)
    mon_on = 1;
    tx_en = 1'b1;
    @(negedge clk);
    send(8'hA5); send(8'h00); send(8'hFF); send(8'h01); send(8'h80);
    drain();
    check(txd == 1'b1, "R5 idle high after frames", txd, 1);
    begin
      int p0;
      p0 = pops;
      repeat (20) @(negedge clk);
      check(pops == p0, "R4 no pop with empty queue", pops, p0);
      check(txd == 1'b1, "R5 idle stays high", txd, 1);
    end

    // even parity (R3)
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h3C); send(8'h07); send(8'h00);
    drain();
    // odd parity (R3)
    par_odd = 1'b1;
    send(8'h5A); send(8'h01); send(8'hFF);
    drain();
    par_en = 1'b0; par_odd = 1'b0;

    // abort mid-frame (R6)
    mon_on = 0;
    @(negedge clk);
    fq.push_back(8'hA5); fq.push_back(8'h3C);
    while (fq.size() != 1) @(negedge clk);
    repeat (10) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    check(txd == 1'b1, "R6 line high after abort", txd, 1);
    check(fq.size() == 1, "R6 queue kept", fq.size(), 1);
    repeat (20) @(negedge clk);
    check(txd == 1'b1, "R6 stays high while disabled", txd, 1);
    check(fq.size() == 1, "R4 no start while disabled", fq.size(), 1);
    eq.push_back(8'h3C);
    mon_on = 1;
    tx_en = 1'b1;
    drain();
    check(fq.size() == 0, "R6 kept byte sent after enable", fq.size(), 0);

    // break sequence during a frame (R7, R8, R9)
    mon_on = 0;
    fq.push_back(8'hFF);
    while (fq.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    pin_dat = 1'b0;
    @(negedge clk) pin_mode = 2'b10;
    @(negedge clk);
    check(txd == 1'b0, "R7 override low while shifting", txd, 0);
    tx_en = 1'b0;
    @(negedge clk);
    check(txd == 1'b0, "R7 break low", txd, 0);
    check(txd_oe == 1'b1, "R7 break driven", txd_oe, 1);
    repeat (40) @(negedge clk);
    check(txd == 1'b0, "R7 break held", txd, 0);
    pin_mode = 2'b01;
    #1;
    check(txd_oe == 1'b0, "R8 mode 01 released", txd_oe, 0);
    check(txd == 1'b1, "R8 mode 01 reads high", txd, 1);
    pin_mode = 2'b11;
    #1;
    check(txd_oe == 1'b0, "R8 mode 11 released", txd_oe, 0);
    check(txd == 1'b1, "R8 mode 11 reads high", txd, 1);
    pin_mode = 2'b10; pin_dat = 1'b1;
    #1;
    check(txd == 1'b1, "R7 drive high", txd, 1);
    pin_mode = 2'b00;
    #1;
    check(txd == 1'b1 && txd_oe == 1'b1, "R9 serial idle high", {txd, txd_oe}, 3);

    // serial again after break (R9)
    @(negedge clk);
    mon_on = 1;
    tx_en = 1'b1;
    send(8'hC3);
    drain();
    finish_run();
  end
endmodule